// File: doc/BRIEF.md
# Row Open Time Limiter

This block sits beside the command path of a DRAM controller that runs an open-row policy. Rows stay open after an access, so that later hits are cheap. A row held open for a long time disturbs its physical neighbours, so the block keeps one open-time counter per bank. Each counter starts when that bank is activated. When the counter reaches a programmable cap, the block raises a forced-precharge request for that bank. The request is raised even if column hits to the row are still waiting.

The cap applies from activation to precharge, whatever traffic runs in between. For that reason, column accesses are not inputs to the block. The cap is chosen from six settings: 36, 66, 96, 186, 336 or 636 ns. The block turns the chosen setting into clock cycles from the clock period parameter, rounding up.

The block also counts activations per row in a small table. Long open times lower the number of activations needed to flip a bit, so the alarm threshold is a register that is set below the plain hammering figure. When a row reaches that threshold, the block asks for a refresh of the row below and the row above, and it drops the row's entry. A pulse that marks the end of each refresh window clears all counts. The cap and the threshold can only be written while every bank is closed.

Top module: `row_open_limiter`

## Requirements
- R1: After reset, no forced-precharge request and no neighbour-refresh request is raised. The cap setting is code 0 (36 ns) and the threshold is DEF_THRESH.
- R2: The forced-precharge request of a bank rises on the clock edge that lies exactly CAPC edges after the edge that sampled its activate. CAPC is ceil(ns*1000/CLK_PS) for the setting in force. For codes 0 to 5 the settings are 36, 66, 96, 186, 336 and 636 ns. With CLK_PS=1250 this gives 29, 53, 77, 149, 269 and 509 cycles.
- R3: A raised forced-precharge request stays high until a precharge to that bank is sampled. It is low from the edge that samples that precharge.
- R4: A precharge sampled before the cap expires stops that bank's timer, and no request follows.
- R5: Each bank's timer runs independently of every other bank's.
- R6: When an activate brings its bank/row count to the threshold, nbr_valid is high for the one cycle after that edge. In that cycle nbr_row_lo is row-1 and nbr_row_hi is row+1. The row's entry is then dropped, so its next activate counts as 1.
- R7: nbr_lo_vld is low when the row is 0, and nbr_hi_vld is low when the row is the highest row. Otherwise both are high.
- R8: If an activate misses the table and no entry is free, the entry with the lowest count is replaced; on a tie, the lowest index is replaced. The new row takes that count plus one.
- R9: A win_end pulse clears every count. An activate sampled together with win_end counts as the first activate of the new window.
- R10: A configuration write takes effect only when every bank is closed, cfg_code is at most 5 and cfg_thresh is nonzero. Any other write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Active-low synchronous reset |
| act_valid | input | 1 | Activate command issued this cycle |
| act_bank | input | BANK_W | Bank of the activate |
| act_row | input | ROW_W | Row of the activate |
| pre_valid | input | 1 | Precharge command issued this cycle |
| pre_bank | input | BANK_W | Bank of the precharge |
| win_end | input | 1 | Pulse marking the end of a refresh window |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_code | input | 3 | Cap setting code (0 to 5) |
| cfg_thresh | input | CNT_W | Adjusted activation threshold |
| fpre_req | output | NUM_BANKS | Forced-precharge request per bank |
| nbr_valid | output | 1 | Neighbour-refresh request |
| nbr_row_lo | output | ROW_W | Row below the aggressor |
| nbr_row_hi | output | ROW_W | Row above the aggressor |
| nbr_lo_vld | output | 1 | Row below exists |
| nbr_hi_vld | output | 1 | Row above exists |

## Verification
The assertions assume a legal command stream. A bank is never activated while it is open. An activate and a precharge to the same bank never share a cycle. A forced request is answered only by a precharge from the scheduler. The bench keeps to these rules: each activate is followed by its precharge before that bank is used again, and it drives at most one command of each kind per cycle. Illegal configuration writes (open banks, code 7) are sent on purpose, because R10 requires them to be ignored.

// File: rtl/rol_pkg.sv
package rol_pkg;

   localparam int unsigned NUM_CAP_CODES = 6;

   // open-time cap settings in nanoseconds, indexed by code
   function automatic int unsigned cap_ns(input logic [2:0] code);
      case (code)
         3'd0:    cap_ns = 36;
         3'd1:    cap_ns = 66;
         3'd2:    cap_ns = 96;
         3'd3:    cap_ns = 186;
         3'd4:    cap_ns = 336;
         default: cap_ns = 636;
      endcase
   endfunction

   // ceil(ns / clock period) with the period given in picoseconds
   function automatic int unsigned cap_cycles(input logic [2:0] code, input int unsigned clk_ps);
      cap_cycles = (cap_ns(code) * 1000 + clk_ps - 1) / clk_ps;
   endfunction

endpackage

// File: rtl/rol_bank_timer.sv
module rol_bank_timer #(
   parameter int OT_W = 10
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            act_hit,
   input  logic            pre_hit,
   input  logic [OT_W-1:0] cap_cyc,
   output logic            open_o,
   output logic            fpre_o
);

   logic [OT_W-1:0] cnt_q;
   logic [OT_W:0]   cnt_inc;

   assign cnt_inc = {1'b0, cnt_q} + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         open_o <= 1'b0;
         fpre_o <= 1'b0;
         cnt_q  <= '0;
      end else if (pre_hit) begin
         open_o <= 1'b0;
         fpre_o <= 1'b0;
         cnt_q  <= '0;
      end else if (act_hit) begin
         open_o <= 1'b1;
         fpre_o <= 1'b0;
         cnt_q  <= '0;
      end else if (open_o && !fpre_o) begin
         cnt_q <= cnt_inc[OT_W-1:0];
         if (cnt_inc >= {1'b0, cap_cyc}) fpre_o <= 1'b1;
      end
   end

endmodule

// File: rtl/rol_cfg.sv
module rol_cfg #(
   parameter int          OT_W       = 10,
   parameter int          CNT_W      = 8,
   parameter int unsigned CLK_PS     = 1250,
   parameter int unsigned DEF_CODE   = 0,
   parameter int unsigned DEF_THRESH = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             all_idle,
   input  logic             cfg_we,
   input  logic [2:0]       cfg_code,
   input  logic [CNT_W-1:0] cfg_thresh,
   output logic [OT_W-1:0]  cap_cyc,
   output logic [CNT_W-1:0] thresh
);

   logic [2:0]      code_q;
   logic [OT_W-1:0] cap_lut [8];

   // constant lookup of cycle counts; codes above the last fold onto it
   for (genvar g = 0; g < 8; g++) begin : g_lut
      localparam int unsigned CODE = (g < rol_pkg::NUM_CAP_CODES) ? g : rol_pkg::NUM_CAP_CODES - 1;
      assign cap_lut[g] = OT_W'(rol_pkg::cap_cycles(3'(CODE), CLK_PS));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         code_q <= 3'(DEF_CODE);
         thresh <= CNT_W'(DEF_THRESH);
      end else if (cfg_we && all_idle && (cfg_code < 3'(rol_pkg::NUM_CAP_CODES)) && (cfg_thresh != '0)) begin
         code_q <= cfg_code;
         thresh <= cfg_thresh;
      end
   end

   assign cap_cyc = cap_lut[code_q];

endmodule

// File: rtl/rol_act_table.sv
module rol_act_table #(
   parameter int BANK_W = 2,
   parameter int ROW_W  = 8,
   parameter int CNT_W  = 8,
   parameter int DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_valid,
   input  logic [BANK_W-1:0] act_bank,
   input  logic [ROW_W-1:0]  act_row,
   input  logic              win_end,
   input  logic [CNT_W-1:0]  thresh,
   output logic              nbr_valid,
   output logic [ROW_W-1:0]  nbr_row_lo,
   output logic [ROW_W-1:0]  nbr_row_hi,
   output logic              nbr_lo_vld,
   output logic              nbr_hi_vld
);

   localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [ROW_W-1:0] ROW_TOP = '1;

   logic [DEPTH-1:0]  v_q;
   logic [CNT_W-1:0]  c_q [DEPTH];
   logic [BANK_W-1:0] b_q [DEPTH];
   logic [ROW_W-1:0]  r_q [DEPTH];

   logic [DEPTH-1:0]  base_v;
   logic              hit, has_free, fire;
   logic [IDX_W-1:0]  hit_idx, free_idx, min_idx, tgt_idx;
   logic [CNT_W:0]    new_cnt;

   always_comb begin
      hit      = 1'b0;
      has_free = 1'b0;
      hit_idx  = '0;
      free_idx = '0;
      min_idx  = '0;
      for (int i = 0; i < DEPTH; i++) begin
         base_v[i] = v_q[i] & ~win_end;
         if (!hit && base_v[i] && (b_q[i] == act_bank) && (r_q[i] == act_row)) begin
            hit     = 1'b1;
            hit_idx = IDX_W'(i);
         end
         if (!has_free && !base_v[i]) begin
            has_free = 1'b1;
            free_idx = IDX_W'(i);
         end
         if (c_q[i] < c_q[min_idx]) min_idx = IDX_W'(i);
      end
      if (hit) begin
         tgt_idx = hit_idx;
         new_cnt = {1'b0, c_q[hit_idx]} + 1'b1;
      end else if (has_free) begin
         tgt_idx = free_idx;
         new_cnt = (CNT_W+1)'(1);
      end else begin
         tgt_idx = min_idx;
         new_cnt = {1'b0, c_q[min_idx]} + 1'b1;
      end
      fire = act_valid && (new_cnt >= {1'b0, thresh});
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= '0;
         for (int i = 0; i < DEPTH; i++) begin
            c_q[i] <= '0;
            b_q[i] <= '0;
            r_q[i] <= '0;
         end
      end else begin
         v_q <= base_v;
         if (act_valid) begin
            if (fire) begin
               if (hit) v_q[hit_idx] <= 1'b0;
            end else begin
               v_q[tgt_idx] <= 1'b1;
               c_q[tgt_idx] <= new_cnt[CNT_W-1:0];
               b_q[tgt_idx] <= act_bank;
               r_q[tgt_idx] <= act_row;
            end
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nbr_valid  <= 1'b0;
         nbr_row_lo <= '0;
         nbr_row_hi <= '0;
         nbr_lo_vld <= 1'b0;
         nbr_hi_vld <= 1'b0;
      end else begin
         nbr_valid  <= fire;
         nbr_row_lo <= act_row - 1'b1;
         nbr_row_hi <= act_row + 1'b1;
         nbr_lo_vld <= (act_row != '0);
         nbr_hi_vld <= (act_row != ROW_TOP);
      end
   end

endmodule

// File: rtl/row_open_limiter.sv
module row_open_limiter #(
   parameter int          NUM_BANKS  = 4,
   parameter int          ROW_W      = 8,
   parameter int          CNT_W      = 8,
   parameter int          DEPTH      = 4,
   parameter int unsigned CLK_PS     = 1250,
   parameter int unsigned DEF_CODE   = 0,
   parameter int unsigned DEF_THRESH = 4,
   localparam int         BANK_W     = $clog2(NUM_BANKS)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 act_valid,
   input  logic [BANK_W-1:0]    act_bank,
   input  logic [ROW_W-1:0]     act_row,
   input  logic                 pre_valid,
   input  logic [BANK_W-1:0]    pre_bank,
   input  logic                 win_end,
   input  logic                 cfg_we,
   input  logic [2:0]           cfg_code,
   input  logic [CNT_W-1:0]     cfg_thresh,
   output logic [NUM_BANKS-1:0] fpre_req,
   output logic                 nbr_valid,
   output logic [ROW_W-1:0]     nbr_row_lo,
   output logic [ROW_W-1:0]     nbr_row_hi,
   output logic                 nbr_lo_vld,
   output logic                 nbr_hi_vld
);

   localparam int OT_W = $clog2(rol_pkg::cap_cycles(3'd5, CLK_PS) + 1);

   if (NUM_BANKS < 2 || (1 << BANK_W) != NUM_BANKS) begin : g_bad_banks
      $error("NUM_BANKS must be a power of two of at least 2");
   end
   if (DEPTH < 1) begin : g_bad_depth
      $error("DEPTH must be at least 1");
   end
   if (DEF_CODE >= rol_pkg::NUM_CAP_CODES) begin : g_bad_code
      $error("DEF_CODE out of range");
   end
   if (DEF_THRESH < 1 || DEF_THRESH >= (1 << CNT_W)) begin : g_bad_thr
      $error("DEF_THRESH must fit CNT_W and be nonzero");
   end
   if (CLK_PS == 0) begin : g_bad_clk
      $error("CLK_PS must be nonzero");
   end

   logic [NUM_BANKS-1:0] bank_open;
   logic [OT_W-1:0]      cap_cyc;
   logic [CNT_W-1:0]     thresh;

   rol_cfg #(
      .OT_W(OT_W), .CNT_W(CNT_W), .CLK_PS(CLK_PS),
      .DEF_CODE(DEF_CODE), .DEF_THRESH(DEF_THRESH)
   ) u_cfg (
      .clk(clk), .rst_n(rst_n), .all_idle(bank_open == '0),
      .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_thresh(cfg_thresh),
      .cap_cyc(cap_cyc), .thresh(thresh)
   );

   for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
      rol_bank_timer #(.OT_W(OT_W)) u_tmr (
         .clk(clk), .rst_n(rst_n),
         .act_hit(act_valid && (act_bank == BANK_W'(b))),
         .pre_hit(pre_valid && (pre_bank == BANK_W'(b))),
         .cap_cyc(cap_cyc),
         .open_o(bank_open[b]),
         .fpre_o(fpre_req[b])
      );
   end

   rol_act_table #(
      .BANK_W(BANK_W), .ROW_W(ROW_W), .CNT_W(CNT_W), .DEPTH(DEPTH)
   ) u_tbl (
      .clk(clk), .rst_n(rst_n),
      .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
      .win_end(win_end), .thresh(thresh),
      .nbr_valid(nbr_valid), .nbr_row_lo(nbr_row_lo), .nbr_row_hi(nbr_row_hi),
      .nbr_lo_vld(nbr_lo_vld), .nbr_hi_vld(nbr_hi_vld)
   );

endmodule

// File: rtl/row_open_limiter_chk.sv
module row_open_limiter_chk #(
   parameter int NUM_BANKS = 4,
   parameter int ROW_W     = 8,
   localparam int BANK_W   = $clog2(NUM_BANKS)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 act_valid,
   input logic [BANK_W-1:0]    act_bank,
   input logic                 pre_valid,
   input logic [BANK_W-1:0]    pre_bank,
   input logic [NUM_BANKS-1:0] fpre_req,
   input logic                 nbr_valid,
   input logic [ROW_W-1:0]     nbr_row_lo,
   input logic [ROW_W-1:0]     nbr_row_hi,
   input logic                 nbr_lo_vld,
   input logic                 nbr_hi_vld
);

   logic [NUM_BANKS-1:0] pre_mask;
   logic [NUM_BANKS-1:0] keep;
   logic [ROW_W:0]       span;

   assign pre_mask = pre_valid ? (NUM_BANKS'(1) << pre_bank) : '0;
   assign keep     = fpre_req & ~pre_mask;
   assign span     = {1'b0, nbr_row_hi} - {1'b0, nbr_row_lo};

   AST_PRE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      pre_valid |=> !fpre_req[$past(pre_bank)]);                                  // R3
   AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (keep != '0) |=> ((fpre_req & $past(keep)) == $past(keep)));                // R3
   AST_NO_REQ_AFTER_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      act_valid |=> !fpre_req[$past(act_bank)]);                                  // R2
   AST_NBR_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
      nbr_valid |-> $past(act_valid));                                            // R6
   AST_NBR_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (nbr_valid && nbr_lo_vld && nbr_hi_vld) |-> (span == (ROW_W+1)'(2)));       // R6
   AST_ROW0_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
      (nbr_valid && nbr_row_hi == ROW_W'(1)) |-> !nbr_lo_vld);                    // R7

endmodule

bind row_open_limiter row_open_limiter_chk #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_chk (.*);

// File: tb/row_open_limiter_tb_top.sv
`timescale 1ns/1ps
module row_open_limiter_tb_top;

   localparam int NB = 4;
   localparam int RW = 8;
   localparam int CW = 8;
   localparam int DP = 4;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          act_valid = 1'b0;
   logic [1:0]    act_bank = '0;
   logic [RW-1:0] act_row = '0;
   logic          pre_valid = 1'b0;
   logic [1:0]    pre_bank = '0;
   logic          win_end = 1'b0;
   logic          cfg_we = 1'b0;
   logic [2:0]    cfg_code = '0;
   logic [CW-1:0] cfg_thresh = '0;
   logic [NB-1:0] fpre_req;
   logic          nbr_valid, nbr_lo_vld, nbr_hi_vld;
   logic [RW-1:0] nbr_row_lo, nbr_row_hi;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   always #5 clk = ~clk;

   row_open_limiter #(.NUM_BANKS(NB), .ROW_W(RW), .CNT_W(CW), .DEPTH(DP),
                      .CLK_PS(1250), .DEF_CODE(0), .DEF_THRESH(4)) dut_i (
      .clk(clk), .rst_n(rst_n), .act_valid(act_valid), .act_bank(act_bank), .act_row(act_row),
      .pre_valid(pre_valid), .pre_bank(pre_bank), .win_end(win_end),
      .cfg_we(cfg_we), .cfg_code(cfg_code), .cfg_thresh(cfg_thresh),
      .fpre_req(fpre_req), .nbr_valid(nbr_valid), .nbr_row_lo(nbr_row_lo),
      .nbr_row_hi(nbr_row_hi), .nbr_lo_vld(nbr_lo_vld), .nbr_hi_vld(nbr_hi_vld));

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   int m_open[NB], m_cnt[NB], m_req[NB];
   int m_code, m_thr;
   int tv[DP], tb[DP], tr[DP], tc[DP];
   int e_nv, e_lo, e_hi, e_lov, e_hiv;

   function automatic int capc(int code);
      int ns[6] = '{36, 66, 96, 186, 336, 636};
      return (ns[code] * 1000 + 1249) / 1250;
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int b = 0; b < NB; b++) begin m_open[b] = 0; m_cnt[b] = 0; m_req[b] = 0; end
         for (int i = 0; i < DP; i++) begin tv[i] = 0; tc[i] = 0; tb[i] = 0; tr[i] = 0; end
         m_code = 0; m_thr = 4; e_nv = 0; e_lo = 0; e_hi = 0; e_lov = 0; e_hiv = 0;
      end else begin
         int hit, fr, mn, nc, idle;
         e_nv = 0;
         if (win_end) for (int i = 0; i < DP; i++) tv[i] = 0;
         if (act_valid) begin
            hit = -1; fr = -1; mn = 0;
            for (int i = 0; i < DP; i++) begin
               if (hit < 0 && tv[i] != 0 && tb[i] == act_bank && tr[i] == act_row) hit = i;
               if (fr < 0 && tv[i] == 0) fr = i;
               if (tc[i] < tc[mn]) mn = i;
            end
            nc = (hit >= 0) ? tc[hit] + 1 : (fr >= 0) ? 1 : tc[mn] + 1;
            if (nc >= m_thr) begin
               e_nv = 1;
               e_lo = (act_row + 255) % 256; e_hi = (act_row + 1) % 256;
               e_lov = (act_row != 0); e_hiv = (act_row != 255);
               if (hit >= 0) tv[hit] = 0;
            end else begin
               int t;
               t = (hit >= 0) ? hit : (fr >= 0) ? fr : mn;
               tv[t] = 1; tc[t] = nc; tb[t] = act_bank; tr[t] = act_row;
            end
         end
         idle = 1;
         for (int b = 0; b < NB; b++) if (m_open[b] != 0) idle = 0;
         for (int b = 0; b < NB; b++) begin
            if (pre_valid && pre_bank == b) begin m_open[b] = 0; m_cnt[b] = 0; m_req[b] = 0; end
            else if (act_valid && act_bank == b) begin m_open[b] = 1; m_cnt[b] = 0; m_req[b] = 0; end
            else if (m_open[b] != 0 && m_req[b] == 0) begin
               m_cnt[b]++;
               if (m_cnt[b] >= capc(m_code)) m_req[b] = 1;
            end
         end
         if (cfg_we && idle != 0 && cfg_code <= 5 && cfg_thresh != 0) begin
            m_code = cfg_code; m_thr = cfg_thresh;
         end
      end
   end

   // compare with the model on every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         for (int b = 0; b < NB; b++) chk("R3 model fpre_req", fpre_req[b], m_req[b]);
         chk("R6 model nbr_valid", nbr_valid, e_nv);
         if (e_nv != 0) begin
            chk("R6 model nbr_row_lo", nbr_row_lo, e_lo);
            chk("R6 model nbr_row_hi", nbr_row_hi, e_hi);
            chk("R7 model nbr_lo_vld", nbr_lo_vld, e_lov);
            chk("R7 model nbr_hi_vld", nbr_hi_vld, e_hiv);
         end
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic do_act(input int bank, input int row, input bit we_pulse);
      @(negedge clk); act_valid = 1; act_bank = 2'(bank); act_row = RW'(row); win_end = we_pulse;
      @(negedge clk); act_valid = 0; win_end = 0;
   endtask

   task automatic do_pre(input int bank);
      @(negedge clk); pre_valid = 1; pre_bank = 2'(bank);
      @(negedge clk); pre_valid = 0;
   endtask

   // activate then precharge on the next cycle; returns the nbr outputs after the activate
   task automatic act_pre(input int row, input bit we_pulse, output int nv, output int lo, output int hi,
                          output int lov, output int hiv);
      @(negedge clk); act_valid = 1; act_bank = 0; act_row = RW'(row); win_end = we_pulse;
      @(negedge clk); act_valid = 0; win_end = 0; pre_valid = 1; pre_bank = 0;
      nv = nbr_valid; lo = nbr_row_lo; hi = nbr_row_hi; lov = nbr_lo_vld; hiv = nbr_hi_vld;
      @(negedge clk); pre_valid = 0;
   endtask

   task automatic measure(input int bank, input int row, output int edges);
      int k;
      do_act(bank, row, 0);
      k = 0;
      while (!fpre_req[bank] && k < 2000) begin @(negedge clk); k++; end
      edges = k;
   endtask

   task automatic cfg_write(input int code, input int thr);
      @(negedge clk); cfg_we = 1; cfg_code = 3'(code); cfg_thresh = CW'(thr);
      @(negedge clk); cfg_we = 0;
   endtask

   task automatic pulse_win;
      @(negedge clk); win_end = 1;
      @(negedge clk); win_end = 0;
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         done = 1;
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      int e, nv, lo, hi, lov, hiv;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk("R1 fpre_req after reset", fpre_req, 0);
      chk("R1 nbr_valid after reset", nbr_valid, 0);

      // R2/R3: default cap 29 cycles, request held then cleared by precharge
      measure(0, 10, e);
      chk("R2 cap cycles code 0", e, 29);
      repeat (15) @(negedge clk);
      chk("R3 request held", fpre_req[0], 1);
      do_pre(0);
      chk("R3 request cleared by precharge", fpre_req[0], 0);

      // R4: early precharge, no request
      do_act(1, 20, 0);
      repeat (20) @(negedge clk);
      do_pre(1);
      repeat (40) @(negedge clk);
      chk("R4 no request after early precharge", fpre_req[1], 0);

      // R5: banks time independently
      do_act(2, 30, 0);
      repeat (8) @(negedge clk);
      do_act(3, 31, 0);
      while (!fpre_req[2]) @(negedge clk);
      chk("R5 bank3 still low when bank2 expires", fpre_req[3], 0);
      repeat (10) @(negedge clk);
      chk("R5 bank3 expires later", fpre_req[3], 1);

      // R10: write while banks open is ignored
      cfg_write(1, 2);
      do_pre(2);
      do_pre(3);
      measure(0, 40, e);
      chk("R10 write with open bank ignored", e, 29);
      do_pre(0);
      cfg_write(7, 3);
      measure(0, 41, e);
      chk("R10 invalid code ignored", e, 29);
      do_pre(0);
      cfg_write(1, 3);
      measure(0, 42, e);
      chk("R2 cap cycles code 1", e, 53);
      do_pre(0);

      // R6: threshold 3 now; start from a clean window
      pulse_win();
      act_pre(50, 0, nv, lo, hi, lov, hiv);
      act_pre(50, 0, nv, lo, hi, lov, hiv);
      chk("R6 below threshold silent", nv, 0);
      act_pre(50, 0, nv, lo, hi, lov, hiv);
      chk("R6 fires at threshold", nv, 1);
      chk("R6 row below", lo, 49);
      chk("R6 row above", hi, 51);
      act_pre(50, 0, nv, lo, hi, lov, hiv);
      chk("R6 entry reset after fire", nv, 0);

      // R7: edge rows
      pulse_win();
      for (int i = 0; i < 3; i++) act_pre(0, 0, nv, lo, hi, lov, hiv);
      chk("R7 row 0 no lower neighbour", lov, 0);
      chk("R7 row 0 upper neighbour", hiv, 1);
      for (int i = 0; i < 3; i++) act_pre(255, 0, nv, lo, hi, lov, hiv);
      chk("R7 top row no upper neighbour", hiv, 0);
      chk("R7 top row lower neighbour", lov, 1);

      // R8: full table replaces the lowest count
      pulse_win();
      act_pre(1, 0, nv, lo, hi, lov, hiv); act_pre(1, 0, nv, lo, hi, lov, hiv);
      act_pre(2, 0, nv, lo, hi, lov, hiv);
      act_pre(3, 0, nv, lo, hi, lov, hiv); act_pre(3, 0, nv, lo, hi, lov, hiv);
      act_pre(4, 0, nv, lo, hi, lov, hiv); act_pre(4, 0, nv, lo, hi, lov, hiv);
      act_pre(5, 0, nv, lo, hi, lov, hiv);
      chk("R8 replacement inherits min+1 below threshold", nv, 0);
      act_pre(5, 0, nv, lo, hi, lov, hiv);
      chk("R8 replaced row fires on second activate", nv, 1);
      chk("R8 replaced row below", lo, 4);

      // R9: window end clears counts; same-cycle activate counts as first
      pulse_win();
      act_pre(7, 0, nv, lo, hi, lov, hiv); act_pre(7, 0, nv, lo, hi, lov, hiv);
      pulse_win();
      act_pre(7, 0, nv, lo, hi, lov, hiv);
      chk("R9 count cleared by window end", nv, 0);
      act_pre(7, 0, nv, lo, hi, lov, hiv);
      act_pre(8, 0, nv, lo, hi, lov, hiv); act_pre(8, 0, nv, lo, hi, lov, hiv);
      act_pre(8, 1, nv, lo, hi, lov, hiv);
      chk("R9 activate with window end counts as first", nv, 0);
      act_pre(8, 0, nv, lo, hi, lov, hiv);
      chk("R9 second in new window silent", nv, 0);
      act_pre(8, 0, nv, lo, hi, lov, hiv);
      chk("R9 third in new window fires", nv, 1);

      // longest cap setting
      cfg_write(5, 3);
      measure(1, 60, e);
      chk("R2 cap cycles code 5", e, 509);
      do_pre(1);
      repeat (3) @(negedge clk);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule